// File: doc/BRIEF.md
# Separate-I/O Synchronous RAM with Selectable Write Output

This block is a clocked model of a static RAM whose data input and data output are separate buses. An active-low chip select and an active-low write strobe are sampled on each rising clock edge. A selected cycle with the strobe high is a read. A selected cycle with the strobe low is a write. An unselected cycle puts the block into standby and stores nothing.

All output responses appear one clock after the inputs are sampled. Instead of a three-state bus, the block has an output-enable flag, and it drives the data bus to zero whenever the flag is low.

A mode parameter sets what the outputs do during a write. In standard mode they float. In transparent mode they echo the word being written. Depth is set by the address width: the nominal organisation is 2^18 words of 4 bits, and smaller depths are used for simulation.

Top module: `sepio_ram`

## Requirements
- R1: While reset is sampled low, the block takes its reset state on the next cycle: `dout`=0, `dout_en`=0, `standby`=1.
- R2: A cycle with `cs_n`=1 gives `dout_en`=0 and `dout`=0 on the next cycle, whatever the value of `we_n`. It also leaves every stored word unchanged.
- R3: A cycle with `cs_n`=0 and `we_n`=1 gives `dout_en`=1 on the next cycle, with `dout` equal to the word stored at `addr`.
- R4: A cycle with `cs_n`=0 and `we_n`=0 stores `din` at `addr`. Other locations are left unchanged.
- R5: With `WR_MODE`=0 (standard), a write cycle gives `dout_en`=0 and `dout`=0 on the next cycle.
- R6: With `WR_MODE`=1 (transparent), a write cycle gives `dout_en`=1 on the next cycle, with `dout` equal to the `din` that was sampled.
- R7: `standby` is 1 on the cycle after `cs_n` is sampled 1, and 0 on the cycle after `cs_n` is sampled 0.
- R8: A read of a location on the cycle right after that location was written returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Output data; 0 while not driven |
| dout_en | output | 1 | High when the output drivers would be active |
| standby | output | 1 | Power-down indicator |

## Verification
The bench builds two instances side by side with a 4-bit address:
- `uut` uses `WR_MODE`=1.
- `uut_std` uses `WR_MODE`=0.

Both instances receive the same stimulus, so every write cycle compares the floating behaviour against the echoing behaviour. The small depth brings every location, including the top address, within reach. It also lets a deselected cycle with the write strobe low be followed by a read-back of the very location it was aimed at. Back-to-back write-then-read pairs and pseudo-random mixes of all three operations run after a directed phase.

// File: rtl/sepio_ram_pkg.sv
// Shared types for the separate-I/O RAM.
// Assumes: operation codes are only produced by ram_op_decode.
package sepio_ram_pkg;

    // Operation sampled on a clock edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } ram_op_e;

    // Write-output behaviour selected by WR_MODE
    localparam int unsigned MODE_STANDARD    = 0;
    localparam int unsigned MODE_TRANSPARENT = 1;

    // Map the two active-low controls onto an operation
    function automatic ram_op_e decode_op(input logic cs_n, input logic we_n);
        if (cs_n)      return OP_IDLE;
        else if (we_n) return OP_READ;
        else           return OP_WRITE;
    endfunction

endpackage

// File: rtl/ram_op_decode.sv
// Decodes the control pins and registers the operation and the write word
// for the output stage. Assumes synchronous active-low reset.
module ram_op_decode
    import sepio_ram_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] din,
    output ram_op_e           op_now,
    output ram_op_e           op_q,
    output logic [DATA_W-1:0] din_q
);

    // Combinational operation for the array in this cycle
    always_comb begin
        op_now = decode_op(cs_n, we_n);
    end

    // Register the operation and the write word for next-cycle output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_IDLE;
            din_q <= '0;
        end else begin
            op_q  <= op_now;
            din_q <= din;
        end
    end

endmodule

// File: rtl/ram_cell_array.sv
// Word array with one synchronous write port and one synchronous read port.
// A read returns the contents as of the sampling edge. Contents are not
// reset. Assumes read and write never coincide (guaranteed by the decoder).
module ram_cell_array
    import sepio_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  ram_op_e           op_now,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the input word on a write cycle
    always_ff @(posedge clk) begin
        if (op_now == OP_WRITE) begin
            cells[addr] <= wdata;
        end
    end

    // Capture the addressed word on a read cycle
    always_ff @(posedge clk) begin
        if (op_now == OP_READ) begin
            rdata <= cells[addr];
        end
    end

endmodule

// File: rtl/ram_out_stage.sv
// Selects what the outputs show, from the registered operation.
// WR_MODE picks floating or echoing outputs during a write.
// Assumes op_q, din_q and rdata all refer to the same sampled cycle.
module ram_out_stage
    import sepio_ram_pkg::*;
#(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned WR_MODE = MODE_STANDARD
) (
    input  ram_op_e           op_q,
    input  logic [DATA_W-1:0] din_q,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic [DATA_W-1:0] wr_word;
    logic              wr_drive;

    generate
        if (WR_MODE == MODE_TRANSPARENT) begin : g_transparent
            // Echo the sampled input word during a write
            always_comb begin
                wr_word  = din_q;
                wr_drive = 1'b1;
            end
        end else begin : g_standard
            // Float the outputs during a write
            always_comb begin
                wr_word  = '0;
                wr_drive = 1'b0;
            end
        end
    endgenerate

    // Output multiplexer by registered operation
    always_comb begin
        unique case (op_q)
            OP_READ: begin
                dout    = rdata;
                dout_en = 1'b1;
            end
            OP_WRITE: begin
                dout    = wr_word;
                dout_en = wr_drive;
            end
            default: begin
                dout    = '0;
                dout_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ram_power_track.sv
// Standby indicator: follows the chip select with one cycle of delay.
// It is set during reset, because the part counts as deselected then.
module ram_power_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic standby
);

    // Register the deselect state
    always_ff @(posedge clk) begin
        if (!rst_n) standby <= 1'b1;
        else        standby <= cs_n;
    end

endmodule

// File: rtl/sepio_ram.sv
// Top level of the separate-I/O synchronous RAM.
// All responses are registered: one cycle from input sample to output.
// Nominal ADDR_W is 18; the default is smaller to keep elaboration light.
module sepio_ram
    import sepio_ram_pkg::*;
#(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned WR_MODE = MODE_STANDARD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              standby
);

    ram_op_e           op_now;
    ram_op_e           op_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] rdata;

    ram_op_decode #(.DATA_W(DATA_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .we_n   (we_n),
        .din    (din),
        .op_now (op_now),
        .op_q   (op_q),
        .din_q  (din_q)
    );

    ram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .op_now (op_now),
        .addr   (addr),
        .wdata  (din),
        .rdata  (rdata)
    );

    ram_out_stage #(.DATA_W(DATA_W), .WR_MODE(WR_MODE)) u_out (
        .op_q    (op_q),
        .din_q   (din_q),
        .rdata   (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

    ram_power_track u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .standby (standby)
    );

endmodule

// File: rtl/sepio_ram_chk.sv
// Port-level property checker for sepio_ram, attached with bind.
module sepio_ram_chk #(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned WR_MODE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              standby
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (standby && !dout_en && dout == '0));

    // R2
    deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cs_n) |-> (!dout_en && dout == '0));

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !cs_n && we_n) |-> dout_en);

    // R7
    standby_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (standby == $past(cs_n)));

    generate
        if (WR_MODE == 1) begin : g_tr
            // R6
            write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n && !cs_n && !we_n) |-> (dout_en && dout == $past(din)));
        end else begin : g_std
            // R5
            write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n && !cs_n && !we_n) |-> (!dout_en && dout == '0));
        end
    endgenerate

endmodule

bind sepio_ram sepio_ram_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_MODE(WR_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .standby(standby)
);

// File: tb/sepio_ram_test.sv
// Bench: two instances (transparent and standard) share one stimulus.
// A behavioural model predicts both on every clock.
module sepio_ram_test;

    localparam int AW = 4;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout_t, dout_s;
    logic en_t, en_s, sb_t, sb_s;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sepio_ram #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(1)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
        .din(din), .dout(dout_t), .dout_en(en_t), .standby(sb_t)
    );

    sepio_ram #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(0)) uut_std (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
        .din(din), .dout(dout_s), .dout_en(en_s), .standby(sb_s)
    );

    // Reference model state
    int mem_m [int];
    int e_dt = 0, e_ds = 0, e_sb = 1;
    bit e_et = 0, e_es = 0;
    bit m_valid = 0;
    string tag = "R1";
    string stag = "R1";
    int last_wr = -1;

    // Model: predict the outputs each edge from the sampled inputs
    always @(posedge clk) begin
        cyc++;
        m_valid = 1;
        if (!rst_n) begin
            e_dt = 0; e_et = 0; e_ds = 0; e_es = 0; e_sb = 1;
            tag = "R1"; stag = "R1";
            last_wr = -1;
        end else if (cs_n) begin
            e_dt = 0; e_et = 0; e_ds = 0; e_es = 0; e_sb = 1;
            tag = "R2"; stag = "R7";
            last_wr = -1;
        end else if (we_n) begin
            e_dt = mem_m.exists(int'(addr)) ? mem_m[int'(addr)] : 0;
            e_ds = e_dt; e_et = 1; e_es = 1; e_sb = 0;
            tag = (last_wr == int'(addr)) ? "R8" : "R3";
            stag = "R7";
            last_wr = -1;
        end else begin
            // R4: store in the model
            mem_m[int'(addr)] = int'(din);
            e_dt = int'(din); e_et = 1; e_ds = 0; e_es = 0; e_sb = 0;
            tag = "R6"; stag = "R7";
            last_wr = int'(addr);
        end
    end

    task automatic check(string t, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", t, what, act, exp, cyc);
        end
    endtask

    // Compare both instances away from the active edge
    always @(negedge clk) begin
        if (m_valid) begin
            check(tag, int'(dout_t), e_dt, "transparent dout");
            check(tag, int'(en_t), int'(e_et), "transparent dout_en");
            check(tag == "R6" ? "R5" : tag, int'(dout_s), e_ds, "standard dout");
            check(tag == "R6" ? "R5" : tag, int'(en_s), int'(e_es), "standard dout_en");
            check(stag, int'(sb_t), e_sb, "standby");
            check(stag, int'(sb_s), e_sb, "standby std");
        end
    end

    task automatic step(bit c, bit w, int a, int d);
        @(negedge clk);
        cs_n = c; we_n = w; addr = AW'(a); din = DW'(d);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        // R1: reset for a few cycles with writes attempted
        step(0, 0, 3, 9);
        step(1, 1, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        // R4: fill every location, including the top address
        for (int i = 0; i < 16; i++) step(0, 0, i, (i * 7 + 3) % 16);
        // R3: read back in reverse order
        for (int i = 15; i >= 0; i--) step(0, 1, i, 0);
        // R2: deselected cycles with the strobe low must not store
        step(1, 0, 5, 15);
        step(1, 1, 6, 0);
        step(1, 0, 6, 1);
        step(0, 1, 5, 0);
        step(0, 1, 6, 0);
        // R7: toggle chip select
        step(1, 1, 0, 0);
        step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        // R8: write then read the same location, back to back
        for (int i = 0; i < 16; i += 3) begin
            step(0, 0, i, 15 - i);
            step(0, 1, i, 0);
        end
        // R5/R6: consecutive writes with changing data
        for (int i = 0; i < 8; i++) step(0, 0, 15 - i, i + 8);
        // Pseudo-random mix of all operations
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[7] & lfsr[6], lfsr[5] | lfsr[1], int'(lfsr[3:0]), int'(lfsr[7:4]));
        end
        // R1: reset in the middle of a run
        step(0, 1, 2, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 2, 0);
        step(1, 1, 0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule